// File: doc/BRIEF.md
# Stall Protection Supervisor

This block guards a brushless motor drive against a stalled rotor. While the drive is commanded to run, it keeps a digital timeout running. Each time the selected "motor is healthy" evidence appears, the timeout starts again. If the timeout expires, the block latches a protection state. In that state every high-side switch request is forced off, and a status output goes high. Only a stop command or a reset releases the latch.

Two criteria can be selected. The first is the phase-lock indication: a stall is declared when the loop stays out of lock for the whole timeout. A reference clock that goes missing also shows up as a lasting loss of lock, so it is caught the same way. The second is the tachometer pulse: a stall is declared when the pulse shows no transition for the whole timeout.

The timeout is `limit_ticks` ticks of a prescaler that divides the system clock by `PRESC_DIV`. The defaults give timeouts of seconds at typical clock rates.

All asynchronous inputs pass through a two-flop synchroniser. The control is a three-state machine:
- `ST_IDLE`: stopped, not monitoring.
- `ST_WATCH`: running, timeout active.
- `ST_TRIP`: protection latched.

The transitions are:
- `ST_IDLE -> ST_WATCH` when run is requested.
- `ST_WATCH -> ST_IDLE` when run is withdrawn.
- `ST_WATCH -> ST_TRIP` when the timeout expires.
- `ST_TRIP -> ST_IDLE` when run is withdrawn.

Top module: `stall_guard`

## Requirements
- R1: After reset `prot_active` is 0 and `hs_out` equals `hs_in`.
- R2: While `run_req` is 0 (stop), the block never enters protection, however long the criterion stays unmet.
- R3: With `crit_sel`=1 (lock criterion) and `run_req`=1, `prot_active` rises once `lock_ok` has stayed 0 for `limit_ticks`×`PRESC_DIV` cycles. The input synchronisers add at most 4 further cycles. This includes `lock_ok` falling after lock was held, which is how a lost reference clock appears.
- R4: With `crit_sel`=0 (tachometer criterion) and `run_req`=1, `prot_active` rises once `tach_in` has shown no transition for `limit_ticks`×`PRESC_DIV` cycles, plus at most 4 cycles. Transitions spaced closer than that keep protection off indefinitely.
- R5: The criterion that is not selected has no effect. Tach transitions do not prevent a trip in lock mode, and `lock_ok`=1 does not prevent a trip in tachometer mode.
- R6: While `prot_active` is 1, `hs_out` is all zero. While it is 0, `hs_out` equals `hs_in`.
- R7: Once latched, protection stays on while `run_req` stays 1, regardless of `lock_ok` or `tach_in` activity.
- R8: Driving `run_req` to 0 clears protection within 4 cycles. A stop also discards any partly elapsed timeout, so a new run starts a fresh full timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| run_req | input | 1 | 1 = start (monitor), 0 = stop (clears latch) |
| crit_sel | input | 1 | 1 = lock criterion, 0 = tachometer criterion |
| lock_ok | input | 1 | Phase-lock indication, 1 = locked |
| tach_in | input | 1 | Tachometer pulse, any transition counts |
| limit_ticks | input | TW | Timeout length in prescaler ticks |
| hs_in | input | PHASES | High-side switch requests from the commutator |
| hs_out | output | PHASES | Gated high-side switch requests |
| prot_active | output | 1 | 1 while protection is latched |

## Verification
The bench builds the block with `PRESC_DIV`=4 and an 8-bit `limit_ticks`, driven mostly at 5 ticks. A stall therefore trips after about twenty cycles instead of seconds. This puts every state transition, and both criteria, within reach of short vectors. Checks are placed well before and well after the nominal trip point, so that the synchroniser latency cannot blur a verdict. A reduced limit of 2 shows that the timeout is taken from the port. An interrupted run shows that a stop resets the elapsed count.

// File: rtl/stall_pkg.sv
package stall_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WATCH = 2'd1,
        ST_TRIP  = 2'd2
    } sv_state_t;

    localparam int unsigned SYNC_STAGES = 2;
endpackage

// File: rtl/stall_sync.sv
module stall_sync #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/stall_edge.sv
module stall_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic toggled
);
    logic d_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= 1'b0;
        else        d_q <= d;
    end

    assign toggled = d ^ d_q;
endmodule

// File: rtl/stall_timer.sv
module stall_timer #(
    parameter int unsigned PRESC_DIV = 65536,
    parameter int unsigned TW        = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    localparam int unsigned PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
    localparam logic [TW-1:0] CNT_MAX = '1;

    logic          tick;
    logic [TW-1:0] elapsed;

    generate
        if (PRESC_DIV > 1) begin : g_presc
            localparam logic [PW-1:0] LAST = PW'(PRESC_DIV - 1);
            logic [PW-1:0] pcnt;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)            pcnt <= '0;
                else if (restart)      pcnt <= '0;
                else if (pcnt == LAST) pcnt <= '0;
                else                   pcnt <= pcnt + 1'b1;
            end

            assign tick = !restart && (pcnt == LAST);
        end else begin : g_nopresc
            assign tick = !restart;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          elapsed <= '0;
        else if (restart)                    elapsed <= '0;
        else if (tick && elapsed != CNT_MAX) elapsed <= elapsed + 1'b1;
    end

    assign expire = !restart && (elapsed >= limit);
endmodule

// File: rtl/stall_guard.sv
module stall_guard
    import stall_pkg::*;
#(
    parameter int unsigned PHASES    = 3,
    parameter int unsigned PRESC_DIV = 65536,
    parameter int unsigned TW        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_req,
    input  logic              crit_sel,
    input  logic              lock_ok,
    input  logic              tach_in,
    input  logic [TW-1:0]     limit_ticks,
    input  logic [PHASES-1:0] hs_in,
    output logic [PHASES-1:0] hs_out,
    output logic              prot_active
);
    localparam int unsigned NSYNC = 4;

    logic [NSYNC-1:0] sync_q;
    logic             run_s, sel_s, lock_s, tach_s;
    logic             tach_edge;
    logic             restart;
    logic             expire;
    sv_state_t        state, nxt;

    stall_sync #(.W(NSYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({run_req, crit_sel, lock_ok, tach_in}),
        .q     (sync_q)
    );

    assign {run_s, sel_s, lock_s, tach_s} = sync_q;

    stall_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .d       (tach_s),
        .toggled (tach_edge)
    );

    // Timeout restarts outside ST_WATCH and whenever the selected health evidence shows.
    assign restart = (state != ST_WATCH) || (sel_s ? lock_s : tach_edge);

    stall_timer #(.PRESC_DIV(PRESC_DIV), .TW(TW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .limit   (limit_ticks),
        .expire  (expire)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (run_s) nxt = ST_WATCH;
            ST_WATCH: begin
                if (!run_s)      nxt = ST_IDLE;
                else if (expire) nxt = ST_TRIP;
            end
            ST_TRIP:  if (!run_s) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        prot_active = (state == ST_TRIP);
        hs_out      = prot_active ? '0 : hs_in;
    end
endmodule

// File: rtl/stall_guard_chk.sv
module stall_guard_chk #(
    parameter int unsigned PHASES = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              run_s,
    input logic              expire,
    input logic [PHASES-1:0] hs_in,
    input logic [PHASES-1:0] hs_out,
    input logic              prot_active
);
    p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        prot_active |-> (hs_out == '0));

    p_pass_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !prot_active |-> (hs_out == hs_in));

    p_latch_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (prot_active && run_s) |=> prot_active);

    p_stopped_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run_s |=> !prot_active);

    p_trip_cause_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prot_active) |-> $past(expire));

    p_clear_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(prot_active) |-> !$past(run_s));
endmodule

bind stall_guard stall_guard_chk #(.PHASES(PHASES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .run_s       (run_s),
    .expire      (expire),
    .hs_in       (hs_in),
    .hs_out      (hs_out),
    .prot_active (prot_active)
);

// File: tb/stall_guard_tb.sv
module stall_guard_tb;
    localparam int unsigned PHASES = 3;
    localparam int unsigned DIV    = 4;
    localparam int unsigned TW     = 8;
    localparam int unsigned NROWS  = 12;

    // row: run, sel, lock, toggle tach, hs_in[2:0], wait[11:0], expected prot
    localparam logic [19:0] VEC [NROWS] = '{
        {1'b0, 1'b1, 1'b0, 1'b0, 3'b101, 12'd100, 1'b0}, // R2 stopped, unlocked
        {1'b1, 1'b1, 1'b1, 1'b0, 3'b011, 12'd100, 1'b0}, // R3 locked run
        {1'b1, 1'b1, 1'b0, 1'b0, 3'b110, 12'd12,  1'b0}, // R3 lock lost, before timeout
        {1'b1, 1'b1, 1'b0, 1'b0, 3'b111, 12'd20,  1'b1}, // R3 timeout reached
        {1'b1, 1'b1, 1'b1, 1'b1, 3'b111, 12'd60,  1'b1}, // R7 latch holds
        {1'b0, 1'b1, 1'b1, 1'b0, 3'b010, 12'd8,   1'b0}, // R8 stop clears
        {1'b1, 1'b0, 1'b0, 1'b1, 3'b101, 12'd150, 1'b0}, // R4 tach alive
        {1'b1, 1'b0, 1'b0, 1'b0, 3'b001, 12'd12,  1'b0}, // R4 tach stops, early
        {1'b1, 1'b0, 1'b0, 1'b0, 3'b011, 12'd20,  1'b1}, // R4 tach timeout
        {1'b0, 1'b0, 1'b0, 1'b0, 3'b100, 12'd8,   1'b0}, // R8 stop clears
        {1'b1, 1'b0, 1'b1, 1'b0, 3'b111, 12'd40,  1'b1}, // R5 lock ignored in tach mode
        {1'b0, 1'b1, 1'b0, 1'b0, 3'b110, 12'd8,   1'b0}  // R8 stop clears
    };
    string ROW_TAG [NROWS] = '{"R2", "R3", "R3", "R3", "R7", "R8",
                               "R4", "R4", "R4", "R8", "R5", "R8"};

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              run_req = 1'b0;
    logic              crit_sel = 1'b1;
    logic              lock_ok = 1'b0;
    logic              tach_in = 1'b0;
    logic [TW-1:0]     limit_ticks = 8'd5;
    logic [PHASES-1:0] hs_in = '0;
    logic [PHASES-1:0] hs_out;
    logic              prot_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    stall_guard #(.PHASES(PHASES), .PRESC_DIV(DIV), .TW(TW)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_req     (run_req),
        .crit_sel    (crit_sel),
        .lock_ok     (lock_ok),
        .tach_in     (tach_in),
        .limit_ticks (limit_ticks),
        .hs_in       (hs_in),
        .hs_out      (hs_out),
        .prot_active (prot_active)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_out(input string tag, input bit exp_prot);
        check(tag, "prot_active", int'(prot_active), int'(exp_prot));
        check(tag, "hs_out", int'(hs_out), exp_prot ? 0 : int'(hs_in));
    endtask

    task automatic idle(input int n, input bit tog);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (tog && (i % 8 == 0)) tach_in = ~tach_in;
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        hs_in = 3'b101;
        repeat (3) @(negedge clk);
        check_out("R1", 1'b0);
        rst_n = 1'b1;
        idle(2, 1'b0);
        check_out("R1", 1'b0);

        for (int r = 0; r < NROWS; r++) begin
            run_req  = VEC[r][19];
            crit_sel = VEC[r][18];
            lock_ok  = VEC[r][17];
            hs_in    = VEC[r][15:13];
            idle(int'(VEC[r][12:1]), VEC[r][16]);
            check_out(ROW_TAG[r], VEC[r][0]);
        end

        // R3: shorter programmed limit trips sooner
        limit_ticks = 8'd2;
        crit_sel = 1'b1; lock_ok = 1'b0; run_req = 1'b1; hs_in = 3'b011;
        idle(5, 1'b0);
        check_out("R3", 1'b0);
        idle(15, 1'b0);
        check_out("R3", 1'b1);
        run_req = 1'b0;
        idle(8, 1'b0);
        check_out("R8", 1'b0);

        // R8: stop discards a partial timeout
        limit_ticks = 8'd5;
        run_req = 1'b1;
        idle(14, 1'b0);
        check_out("R8", 1'b0);
        run_req = 1'b0;
        idle(6, 1'b0);
        run_req = 1'b1;
        idle(14, 1'b0);
        check_out("R8", 1'b0);
        idle(20, 1'b0);
        check_out("R3", 1'b1);

        // R5: tach activity does not rescue lock mode
        run_req = 1'b0;
        idle(8, 1'b0);
        run_req = 1'b1;
        idle(40, 1'b1);
        check_out("R5", 1'b1);
        run_req = 1'b0;
        idle(8, 1'b0);
        check_out("R8", 1'b0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule